// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block sits between a set of transmit mailboxes and a CAN protocol engine. It decides which pending mailbox the engine should attempt next. Software raises a one-cycle request for a mailbox, and the block captures that mailbox's 11-bit identifier at the same time. The block then presents one selected mailbox index with a valid flag. When the engine finishes an attempt, it returns a single completion strobe and a status for the mailbox that was selected. The block then frees the mailbox, keeps it for another try, or marks it failed.

Two static inputs shape the behaviour. The order-mode bit chooses how the winner is picked. When it is low, the lowest identifier wins. When it is high, the request that arrived first wins. The single-shot bit turns automatic retransmission off, so every frame gets exactly one attempt. Per-mailbox done and failure pulses tell the mailbox owners how each frame ended. Frame serialization and arbitration on the wire are handled elsewhere.

Top module: `txsch_top`

## Requirements
- R1: A request pulse on a mailbox that is not pending makes it pending after the next clock edge, and its identifier is captured from `id_i` on that same edge. A request on a mailbox that is already pending is ignored, including the identifier that comes with it. `sel_valid_o` is high exactly when at least one mailbox is pending.
- R2: With `order_mode_i` = 0, the selected mailbox is the pending mailbox with the numerically smallest identifier.
- R3: With `order_mode_i` = 0, when pending mailboxes share the smallest identifier, the one with the lower index is selected.
- R4: With `order_mode_i` = 1, the selected mailbox is the pending one whose request was accepted earliest. Requests accepted on the same edge are ordered by index, with the lower index counted as older.
- R5: A completion (`attempt_done_i` = 1 while `sel_valid_o` = 1) with status 2'b00 (success) frees the selected mailbox in either retransmit setting. It also pulses that mailbox's bit of `done_o` for one cycle after the edge.
- R6: With `one_shot_i` = 0, a completion with status 2'b01 (error), 2'b10 (arbitration lost) or 2'b11 (also treated as error) leaves the mailbox pending and raises no flag. The mailbox competes again in the next selection.
- R7: With `one_shot_i` = 1, a completion with any non-success status frees the selected mailbox and pulses its bit of `fail_o` for one cycle.
- R8: A completion strobe while no mailbox is pending changes nothing and raises no flag.
- R9: After reset, no mailbox is pending, `sel_valid_o` is 0, and `done_o` and `fail_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_MB | Per-mailbox request pulse |
| id_i | input | NUM_MB*ID_W | Identifiers; mailbox k occupies bits [k*ID_W +: ID_W] |
| order_mode_i | input | 1 | 0: lowest identifier first, 1: oldest request first |
| one_shot_i | input | 1 | 1: one attempt per frame, no retransmission |
| attempt_done_i | input | 1 | Engine finished an attempt on the selected mailbox |
| attempt_status_i | input | 2 | 00 success, 01 error, 10 arbitration lost, 11 error |
| sel_valid_o | output | 1 | A mailbox is offered to the engine |
| sel_idx_o | output | IDX_W | Index of the offered mailbox |
| done_o | output | NUM_MB | One-cycle pulse: frame sent successfully |
| fail_o | output | NUM_MB | One-cycle pulse: single attempt failed |

## Verification
The assertions check the following on every cycle:
- No pending mailbox beats the selected one under the active ordering rule, and identifier ties resolve toward the lower index.
- The age stamps of pending mailboxes stay distinct and in range.
- Each completion outcome leads to exactly the flag and pending state the retransmit setting calls for.

Some behaviour can only be shown by the bench's scenarios against its queue-based model. This includes that a request on a busy mailbox leaves its captured identifier untouched, that arrival order survives many frees and re-requests, and that mode switches in the middle of a run pick the correct winner.

// File: rtl/txsch_pkg.sv
package txsch_pkg;
   typedef enum logic [1:0] {
      ATT_OK  = 2'b00,
      ATT_ERR = 2'b01,
      ATT_ARB = 2'b10,
      ATT_RSV = 2'b11
   } att_status_e;
endpackage

// File: rtl/txsch_age_tracker.sv
// Keeps, for each pending mailbox, the count of pending mailboxes younger than it.
// The oldest pending mailbox carries the largest stamp; stamps stay below NUM_MB.
module txsch_age_tracker #(
   parameter int NUM_MB = 3,
   localparam int IDX_W = $clog2(NUM_MB),
   localparam int AGE_W = $clog2(NUM_MB)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_MB-1:0]      pend_q,
   input  logic [NUM_MB-1:0]      accept,
   input  logic                   free_vld,
   input  logic [IDX_W-1:0]       free_idx,
   output logic [NUM_MB*AGE_W-1:0] ages
);
   logic [AGE_W-1:0] age_q [NUM_MB];
   logic [AGE_W-1:0] freed_age;
   logic [AGE_W-1:0] new_cnt;

   always_comb begin
      new_cnt = '0;
      for (int k = 0; k < NUM_MB; k++) new_cnt = new_cnt + AGE_W'(accept[k]);
      freed_age = age_q[free_idx];
   end

   for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
      logic [AGE_W-1:0] younger_new;
      always_comb begin
         younger_new = '0;
         for (int k = g + 1; k < NUM_MB; k++) younger_new = younger_new + AGE_W'(accept[k]);
      end
      always_ff @(posedge clk) begin
         if (!rst_n) age_q[g] <= '0;
         else if (accept[g]) age_q[g] <= younger_new;
         else if (pend_q[g])
            age_q[g] <= age_q[g] + new_cnt
                        - AGE_W'(free_vld && (age_q[g] > freed_age));
      end
      assign ages[g*AGE_W +: AGE_W] = age_q[g];

      AST_AGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         pend_q[g] |-> (int'(age_q[g]) < NUM_MB)) else $error("age range"); // R4
      for (genvar h = g + 1; h < NUM_MB; h++) begin : g_pair
         AST_AGE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[g] && pend_q[h]) |-> (age_q[g] != age_q[h])) else $error("age clash"); // R4
      end
   end
endmodule

// File: rtl/txsch_arbiter.sv
// Picks one pending mailbox: smallest identifier (ties to lower index) or largest age stamp.
module txsch_arbiter #(
   parameter int NUM_MB = 3,
   parameter int ID_W   = 11,
   localparam int IDX_W = $clog2(NUM_MB),
   localparam int AGE_W = $clog2(NUM_MB)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_MB-1:0]       pend_q,
   input  logic [NUM_MB*ID_W-1:0]  ids,
   input  logic [NUM_MB*AGE_W-1:0] ages,
   input  logic                    order_mode,
   output logic                    sel_valid,
   output logic [IDX_W-1:0]        sel_idx
);
   logic [ID_W-1:0]  best_id;
   logic [AGE_W-1:0] best_age;
   logic             found;

   always_comb begin
      found    = 1'b0;
      sel_idx  = '0;
      best_id  = '0;
      best_age = '0;
      for (int k = 0; k < NUM_MB; k++) begin
         if (pend_q[k]) begin
            if (!found ||
                (order_mode  && (ages[k*AGE_W +: AGE_W] > best_age)) ||
                (!order_mode && (ids[k*ID_W +: ID_W] < best_id))) begin
               found    = 1'b1;
               sel_idx  = IDX_W'(k);
               best_id  = ids[k*ID_W +: ID_W];
               best_age = ages[k*AGE_W +: AGE_W];
            end
         end
      end
      sel_valid = found;
   end

   for (genvar g = 0; g < NUM_MB; g++) begin : g_chk
      AST_ID_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_valid && !order_mode && pend_q[g]) |-> (ids[g*ID_W +: ID_W] >= ids[sel_idx*ID_W +: ID_W]))
         else $error("id order"); // R2
      AST_ID_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_valid && !order_mode && pend_q[g] && (ids[g*ID_W +: ID_W] == ids[sel_idx*ID_W +: ID_W]))
         |-> (g >= int'(sel_idx))) else $error("id tie"); // R3
      AST_OLDEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_valid && order_mode && pend_q[g]) |-> (ages[g*AGE_W +: AGE_W] <= ages[sel_idx*AGE_W +: AGE_W]))
         else $error("age order"); // R4
   end
endmodule

// File: rtl/txsch_top.sv
module txsch_top
   import txsch_pkg::*;
#(
   parameter int NUM_MB = 3,
   parameter int ID_W   = 11,
   localparam int IDX_W = $clog2(NUM_MB),
   localparam int AGE_W = $clog2(NUM_MB)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_MB-1:0]      req_i,
   input  logic [NUM_MB*ID_W-1:0] id_i,
   input  logic                   order_mode_i,
   input  logic                   one_shot_i,
   input  logic                   attempt_done_i,
   input  logic [1:0]             attempt_status_i,
   output logic                   sel_valid_o,
   output logic [IDX_W-1:0]       sel_idx_o,
   output logic [NUM_MB-1:0]      done_o,
   output logic [NUM_MB-1:0]      fail_o
);
   initial begin
      assert (NUM_MB >= 2) else $error("NUM_MB must be at least 2");
      assert (ID_W >= 1)   else $error("ID_W must be positive");
   end

   logic [NUM_MB-1:0]       pend_q, accept;
   logic [NUM_MB*ID_W-1:0]  id_q;
   logic [NUM_MB*AGE_W-1:0] ages;
   att_status_e             status;
   logic                    compl_live, outcome_ok, release_sel;

   assign status      = att_status_e'(attempt_status_i);
   assign accept      = req_i & ~pend_q;
   assign compl_live  = attempt_done_i && sel_valid_o;
   assign outcome_ok  = (status == ATT_OK);
   assign release_sel = compl_live && (outcome_ok || one_shot_i);

   for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
      logic hit;
      assign hit = (sel_idx_o == IDX_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q[g] <= 1'b0;
            id_q[g*ID_W +: ID_W] <= '0;
            done_o[g] <= 1'b0;
            fail_o[g] <= 1'b0;
         end else begin
            if (accept[g]) begin
               pend_q[g] <= 1'b1;
               id_q[g*ID_W +: ID_W] <= id_i[g*ID_W +: ID_W];
            end else if (release_sel && hit) begin
               pend_q[g] <= 1'b0;
            end
            done_o[g] <= compl_live && hit && outcome_ok;
            fail_o[g] <= compl_live && hit && !outcome_ok && one_shot_i;
         end
      end
   end

   txsch_age_tracker #(.NUM_MB(NUM_MB)) u_age (
      .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .accept(accept),
      .free_vld(release_sel), .free_idx(sel_idx_o), .ages(ages));

   txsch_arbiter #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .ids(id_q), .ages(ages),
      .order_mode(order_mode_i), .sel_valid(sel_valid_o), .sel_idx(sel_idx_o));

   AST_VALID_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid_o == (pend_q != '0)) else $error("valid"); // R1
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done_o | fail_o)) else $error("flags"); // R5
   AST_OK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (compl_live && outcome_ok) |=> ($countones(done_o) == 1 && fail_o == '0)) else $error("done"); // R5
   AST_RETRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (compl_live && !outcome_ok && !one_shot_i) |=> (pend_q[$past(sel_idx_o)] && done_o == '0 && fail_o == '0))
      else $error("retry"); // R6
   AST_ONESHOT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (compl_live && !outcome_ok && one_shot_i) |=> ($countones(fail_o) == 1 && done_o == '0))
      else $error("one shot"); // R7
   AST_IDLE_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
      (attempt_done_i && !sel_valid_o) |=> (done_o == '0 && fail_o == '0)) else $error("idle"); // R8
endmodule

// File: tb/txsch_top_test.sv
`timescale 1ns/1ps
module txsch_top_test;
   localparam int N = 3;
   localparam int W = 11;

   logic clk = 0, rst_n = 0;
   logic [N-1:0] req = '0;
   logic [N*W-1:0] ids = '0;
   logic order_mode = 0, one_shot = 0, att_done = 0;
   logic [1:0] att_st = 0;
   logic sel_valid;
   logic [1:0] sel_idx;
   logic [N-1:0] done_o, fail_o;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   txsch_top #(.NUM_MB(N), .ID_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .id_i(ids), .order_mode_i(order_mode),
      .one_shot_i(one_shot), .attempt_done_i(att_done), .attempt_status_i(att_st),
      .sel_valid_o(sel_valid), .sel_idx_o(sel_idx), .done_o(done_o), .fail_o(fail_o));

   // behavioural reference model
   bit   m_pend [N];
   int   m_id [N];
   int   m_q [$];
   logic [N-1:0] m_done, m_fail;

   function automatic int m_sel();
      int b = -1;
      if (order_mode) return (m_q.size() > 0) ? m_q[0] : -1;
      for (int k = 0; k < N; k++)
         if (m_pend[k] && (b < 0 || m_id[k] < m_id[b])) b = k;
      return b;
   endfunction

   task automatic m_free(int s);
      m_pend[s] = 0;
      foreach (m_q[j]) if (m_q[j] == s) begin m_q.delete(j); break; end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < N; k++) begin m_pend[k] = 0; m_id[k] = 0; end
         m_q.delete();
         m_done = '0; m_fail = '0;
      end else begin
         bit old [N];
         int s;
         for (int k = 0; k < N; k++) old[k] = m_pend[k];
         s = m_sel();
         m_done = '0; m_fail = '0;
         if (att_done && s >= 0) begin
            if (att_st == 2'b00) begin m_free(s); m_done[s] = 1; end
            else if (one_shot) begin m_free(s); m_fail[s] = 1; end
         end
         for (int k = 0; k < N; k++)
            if (req[k] && !old[k]) begin
               m_pend[k] = 1; m_id[k] = int'(ids[k*W +: W]); m_q.push_back(k);
            end
      end
   end

   task automatic chk(int act, int exp, string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      int s = m_sel();
      chk(int'(sel_valid), (s >= 0) ? 1 : 0, "R1");
      if (s >= 0) chk(int'(sel_idx), s, order_mode ? "R4" : "R2");
      chk(int'(done_o), int'(m_done), "R5");
      chk(int'(fail_o), int'(m_fail), "R7");
   endtask

   // compare at the negedge, then drive inputs for the next posedge
   task automatic step(logic [N-1:0] r, int i0, int i1, int i2, bit d, logic [1:0] st);
      @(negedge clk);
      compare();
      req = r;
      ids = {W'(i2), W'(i1), W'(i0)};
      att_done = d;
      att_st = st;
   endtask

   task automatic idle(); step('0, 0, 0, 0, 0, 0); endtask
   task automatic drain();
      for (int k = 0; k < 4; k++) step('0, 0, 0, 0, 1, 2'b00);
      idle();
   endtask

   initial begin
      #(200000 * 5);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      if (!finished) begin
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(int'(sel_valid), 0, "R9");
      chk(int'(done_o | fail_o), 0, "R9");

      // R2: lowest identifier wins
      step(3'b111, 'h300, 'h100, 'h200, 0, 0);
      idle();
      chk(int'(sel_idx), 1, "R2");
      step('0, 0, 0, 0, 1, 2'b00);
      idle();
      chk(int'(done_o), 3'b010, "R5");
      chk(int'(sel_idx), 2, "R2");
      drain();

      // R3: equal identifiers, lower index wins
      step(3'b101, 'h55, 0, 'h55, 0, 0);
      idle();
      chk(int'(sel_idx), 0, "R3");
      drain();

      // R1: request on a busy mailbox ignores its new identifier
      step(3'b011, 'h400, 'h300, 0, 0, 0);
      step(3'b001, 'h001, 0, 0, 0, 0);
      idle();
      chk(int'(sel_idx), 1, "R1");
      drain();

      // R6: retry keeps the mailbox after error and arbitration loss
      step(3'b100, 0, 0, 'h005, 0, 0);
      step('0, 0, 0, 0, 1, 2'b01);
      idle();
      chk(int'(sel_valid), 1, "R6");
      chk(int'(sel_idx), 2, "R6");
      chk(int'(fail_o | done_o), 0, "R6");
      step('0, 0, 0, 0, 1, 2'b10);
      idle();
      chk(int'(sel_idx), 2, "R6");
      chk(int'(fail_o | done_o), 0, "R6");
      drain();

      // R7: single attempt, failure frees and flags
      one_shot = 1;
      step(3'b010, 0, 'h7, 0, 0, 0);
      step('0, 0, 0, 0, 1, 2'b10);
      idle();
      chk(int'(fail_o), 3'b010, "R7");
      chk(int'(sel_valid), 0, "R7");
      one_shot = 0;

      // R8: completion with nothing pending
      step('0, 0, 0, 0, 1, 2'b00);
      idle();
      chk(int'(done_o | fail_o), 0, "R8");
      chk(int'(sel_valid), 0, "R8");

      // R4: oldest first, same-edge arrivals by index
      order_mode = 1;
      step(3'b100, 0, 0, 'h001, 0, 0);
      step(3'b001, 'h7ff, 0, 0, 0, 0);
      idle();
      chk(int'(sel_idx), 2, "R4");
      step(3'b010, 0, 'h000, 0, 1, 2'b00);
      idle();
      chk(int'(sel_idx), 0, "R4");
      drain();
      step(3'b001, 'h100, 0, 0, 0, 0);
      step(3'b110, 0, 'h050, 'h010, 0, 0);
      step('0, 0, 0, 0, 1, 2'b00);
      idle();
      chk(int'(sel_idx), 1, "R4");
      drain();

      // mixed random traffic, model compared every cycle
      for (int n = 0; n < 600; n++) begin
         if (n % 50 == 0) begin
            order_mode = 1'($urandom);
            one_shot = 1'($urandom);
         end
         step(N'($urandom), int'($urandom % 2048), int'($urandom % 8), int'($urandom % 2048),
              ($urandom % 3) == 0, 2'($urandom));
      end
      idle();

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule